// File: doc/BRIEF.md
# Boot Flash Read Arbiter

This block shares a single serial flash interface between two users: a memory-mapped read engine used during boot, and a software-driven SPI master that sits outside the block. A one-bit owner control decides which user drives the flash clock, data-out and chip-select pins. The multiplexer also routes the flash data-in line back to the owning side only.

In boot ownership, a request on the read port carries a 25-bit byte offset and a length. The offset must fall inside a 32 MiB window. The engine selects the flash and sends the standard read opcode and a 24-bit address. The top address bit goes out on a separate bank pin. The engine then clocks in the requested bytes, hands each one out with a one-cycle valid strobe, and releases the chip select.

A request that would run past the end of the window is refused with an error strobe, and the flash is not touched. Ownership moves to the SPI master only while the read engine is idle. A request to move while a read is in flight is held and carried out once the read finishes. Moving back to boot ownership takes effect at once. After each move to the master, a settle counter tells the master when it may start.

Top module: `flash_boot_arbiter`

## Requirements
- R1: After reset the boot engine owns the pins: `ctl_owner`=0, `boot_busy`=0, `master_ready`=0, `spi_cs_n`=1 and `rd_ready`=1.
- R2: An accepted read drives `spi_cs_n` low and then shifts out, MSB first in SPI mode 0 (data changes while the clock is low and is sampled on the rising clock), the byte 0x03 followed by offset bits 23..0. `spi_bank` carries offset bit 24. The engine then returns exactly `rd_len` bytes in address order, each with a one-cycle `rd_valid`, the first bit received being bit 7.
- R3: A control write of 1 (`ctl_wr`=1, `ctl_wdata`=1) while the engine is idle and no read is being accepted sets `ctl_owner` to 1 in the next cycle.
- R4: A control write of 1 that arrives while `boot_busy` is 1, or in the same cycle that a read is accepted, is held pending. While it is pending, `ctl_owner` stays 0 and `rd_ready` is 0. `ctl_owner` becomes 1 in the cycle after `boot_busy` falls.
- R5: `master_ready` rises exactly SETTLE_CYC cycles after `ctl_owner` becomes 1, and it is 0 whenever `ctl_owner` is 0.
- R6: A request with `rd_len`=0, or with `rd_addr`+`rd_len` greater than 2^25, produces a one-cycle `rd_err` in the next cycle, leaves `boot_busy` at 0 and leaves `spi_cs_n` high. A request that ends exactly at 2^25 is served normally.
- R7: A control write of 0 sets `ctl_owner` to 0 in the next cycle whatever the busy state, and cancels any pending switch to the master.
- R8: While `rd_ready` is 0 (master ownership), `rd_req` is ignored: no `rd_err`, no `boot_busy`, and the flash pins keep following the master inputs.
- R9: With `ctl_owner`=1, `spi_sclk`, `spi_mosi` and `spi_cs_n` follow `m_sclk`, `m_mosi` and `m_cs_n`, and `m_miso` follows `spi_miso`. With `ctl_owner`=0, `m_miso` is 0.
- R10: `boot_busy` is 1 from the cycle after an accepted read until the cycle in which `rd_done` pulses, and `spi_cs_n` is high whenever `boot_busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Owner control write strobe |
| ctl_wdata | input | 1 | Owner value to write: 1 master, 0 boot engine |
| ctl_owner | output | 1 | Current owner: 1 master, 0 boot engine |
| boot_busy | output | 1 | Boot engine flash access in progress |
| master_ready | output | 1 | Settle time after the switch to the master has elapsed |
| rd_req | input | 1 | Mapped read request |
| rd_addr | input | ADDR_W (25) | Byte offset inside the window |
| rd_len | input | LEN_W (8) | Number of bytes to read |
| rd_ready | output | 1 | Read port can accept a request |
| rd_valid | output | 1 | Read data byte strobe |
| rd_data | output | 8 | Read data byte |
| rd_done | output | 1 | Read finished strobe |
| rd_err | output | 1 | Request refused (window or zero length) |
| m_sclk | input | 1 | Master-side serial clock |
| m_mosi | input | 1 | Master-side data out |
| m_cs_n | input | 1 | Master-side chip select, active low |
| m_miso | output | 1 | Flash data returned to the master |
| spi_sclk | output | 1 | Flash serial clock |
| spi_mosi | output | 1 | Flash data in |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_bank | output | ADDR_W-24 (1) | High address bank select |
| spi_miso | input | 1 | Flash data out |

## Verification
Two events can fall in the same cycle: a control write asking for the master, and the acceptance of a mapped read. The bench drives both on the same clock edge. It expects the read to run to completion with correct bytes, `ctl_owner` to stay 0 through the cycle in which `boot_busy` falls, and `ctl_owner` to turn 1 one cycle later. A second case writes 1 during a read and then writes 0 before the read ends. In that case the held switch must be dropped, and the read port must be free again afterwards.

// File: rtl/flash_arb_pkg.sv
package flash_arb_pkg;
  localparam logic [7:0] RD_OPCODE = 8'h03;
  localparam int FLASH_AW = 24;
  localparam int HDR_BITS = 8 + FLASH_AW;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SEL,
    SQ_SHIFT,
    SQ_DESEL,
    SQ_HOLD
  } sq_state_e;
endpackage

// File: rtl/flash_arb_owner_ctl.sv
module flash_arb_owner_ctl #(
  parameter int SETTLE_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic ctl_wdata,
  input  logic eng_claim,
  output logic owner_master,
  output logic switch_pend,
  output logic master_ready
);
  localparam int CNT_W = $clog2(SETTLE_CYC + 2);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(SETTLE_CYC);

  logic             owner_q, owner_d;
  logic             pend_q, pend_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    owner_d = owner_q;
    pend_d  = pend_q;
    if (ctl_wr) begin
      if (!ctl_wdata) begin
        owner_d = 1'b0;
        pend_d  = 1'b0;
      end else if (!owner_q) begin
        if (eng_claim) begin
          pend_d = 1'b1;
        end else begin
          owner_d = 1'b1;
          pend_d  = 1'b0;
        end
      end
    end else if (pend_q && !eng_claim) begin
      owner_d = 1'b1;
      pend_d  = 1'b0;
    end
  end

  always_comb begin
    if (owner_q && owner_d) begin
      cnt_d = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + CNT_W'(1);
    end else begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= 1'b0;
      pend_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      owner_q <= owner_d;
      pend_q  <= pend_d;
      cnt_q   <= cnt_d;
    end
  end

  assign owner_master = owner_q;
  assign switch_pend  = pend_q;
  assign master_ready = owner_q && (cnt_q == CNT_TOP);

  // The master side only gains the pins in a cycle after the engine was quiet
  assert_switch_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(owner_q) |-> !$past(eng_claim));

  assert_pend_boot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    switch_pend |-> !owner_q);

  assert_settle_after_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(master_ready) |-> ((SETTLE_CYC == 0) || $past(owner_q)));
endmodule

// File: rtl/flash_arb_read_seq.sv
module flash_arb_read_seq
  import flash_arb_pkg::*;
#(
  parameter int ADDR_W   = 25,
  parameter int LEN_W    = 8,
  parameter int CLK_HALF = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [LEN_W-1:0]  rd_len,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              rd_done,
  output logic              rd_err,
  output logic              busy,
  output logic              claim,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic [ADDR_W-FLASH_AW-1:0] bank
);
  localparam int CNT_W  = $clog2(HDR_BITS + 8 * (2 ** LEN_W));
  localparam int DIV_W  = $clog2(CLK_HALF + 1);
  localparam int BANK_W = ADDR_W - FLASH_AW;
  localparam logic [ADDR_W:0]    WIN_END  = (ADDR_W + 1)'(1) << ADDR_W;
  localparam logic [DIV_W-1:0]   DIV_LAST = DIV_W'(CLK_HALF - 1);
  localparam logic [CNT_W-1:0]   HDR_CNT  = CNT_W'(HDR_BITS);

  sq_state_e            state_q, state_d;
  logic [DIV_W-1:0]     div_q, div_d;
  logic                 sclk_q, sclk_d;
  logic                 cs_n_q, cs_n_d;
  logic [HDR_BITS-1:0]  tx_q, tx_d;
  logic [7:0]           rx_q, rx_d;
  logic [CNT_W-1:0]     bit_q, bit_d;
  logic [CNT_W-1:0]     last_q, last_d;
  logic [BANK_W-1:0]    bank_q, bank_d;
  logic                 valid_q, valid_d;
  logic [7:0]           data_q, data_d;
  logic                 done_q, done_d;
  logic                 err_q, err_d;

  logic                 fire, bad, start, tick;
  logic [ADDR_W:0]      end_off;

  assign end_off  = {1'b0, rd_addr} + (ADDR_W + 1)'(rd_len);
  assign rd_ready = enable && (state_q == SQ_IDLE);
  assign fire     = rd_req && rd_ready;
  assign bad      = (rd_len == '0) || (end_off > WIN_END);
  assign start    = fire && !bad;
  assign tick     = (div_q == DIV_LAST);

  always_comb begin
    state_d = state_q;
    div_d   = '0;
    sclk_d  = sclk_q;
    cs_n_d  = cs_n_q;
    tx_d    = tx_q;
    rx_d    = rx_q;
    bit_d   = bit_q;
    last_d  = last_q;
    bank_d  = bank_q;
    valid_d = 1'b0;
    data_d  = data_q;
    done_d  = 1'b0;
    err_d   = 1'b0;
    if (state_q != SQ_IDLE) begin
      div_d = tick ? '0 : div_q + DIV_W'(1);
    end
    case (state_q)
      SQ_IDLE: begin
        sclk_d = 1'b0;
        if (fire) begin
          if (bad) begin
            err_d = 1'b1;
          end else begin
            state_d = SQ_SEL;
            cs_n_d  = 1'b0;
            tx_d    = {RD_OPCODE, rd_addr[FLASH_AW-1:0]};
            bank_d  = rd_addr[ADDR_W-1:FLASH_AW];
            bit_d   = '0;
            last_d  = CNT_W'(HDR_BITS - 1) + (CNT_W'(rd_len) << 3);
          end
        end
      end
      SQ_SEL: begin
        if (tick) state_d = SQ_SHIFT;
      end
      SQ_SHIFT: begin
        if (tick) begin
          if (!sclk_q) begin
            sclk_d = 1'b1;
            if (bit_q >= HDR_CNT) begin
              rx_d = {rx_q[6:0], miso};
              if (bit_q[2:0] == 3'd7) begin
                valid_d = 1'b1;
                data_d  = {rx_q[6:0], miso};
              end
            end
          end else begin
            sclk_d = 1'b0;
            if (bit_q == last_q) begin
              state_d = SQ_DESEL;
            end else begin
              bit_d = bit_q + CNT_W'(1);
              tx_d  = {tx_q[HDR_BITS-2:0], 1'b0};
            end
          end
        end
      end
      SQ_DESEL: begin
        if (tick) begin
          cs_n_d  = 1'b1;
          state_d = SQ_HOLD;
        end
      end
      SQ_HOLD: begin
        if (tick) begin
          state_d = SQ_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      div_q   <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      tx_q    <= '0;
      rx_q    <= '0;
      bit_q   <= '0;
      last_q  <= '0;
      bank_q  <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      div_q   <= div_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      bit_q   <= bit_d;
      last_q  <= last_d;
      bank_q  <= bank_d;
      valid_q <= valid_d;
      data_q  <= data_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign busy     = (state_q != SQ_IDLE);
  assign claim    = busy || start;
  assign rd_valid = valid_q;
  assign rd_data  = data_q;
  assign rd_done  = done_q;
  assign rd_err   = err_q;
  assign sclk     = sclk_q;
  assign mosi     = tx_q[HDR_BITS-1];
  assign cs_n     = cs_n_q;
  assign bank     = bank_q;

  assert_err_no_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err |-> !busy);

  assert_data_in_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);

  assert_cs_high_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cs_n_q);

  assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_done |-> $past(busy));
endmodule

// File: rtl/flash_arb_pin_mux.sv
module flash_arb_pin_mux (
  input  logic owner_master,
  input  logic b_sclk,
  input  logic b_mosi,
  input  logic b_cs_n,
  output logic b_miso,
  input  logic m_sclk,
  input  logic m_mosi,
  input  logic m_cs_n,
  output logic m_miso,
  output logic spi_sclk,
  output logic spi_mosi,
  output logic spi_cs_n,
  input  logic spi_miso
);
  always_comb begin
    if (owner_master) begin
      spi_sclk = m_sclk;
      spi_mosi = m_mosi;
      spi_cs_n = m_cs_n;
      m_miso   = spi_miso;
      b_miso   = 1'b0;
    end else begin
      spi_sclk = b_sclk;
      spi_mosi = b_mosi;
      spi_cs_n = b_cs_n;
      m_miso   = 1'b0;
      b_miso   = spi_miso;
    end
  end
endmodule

// File: rtl/flash_boot_arbiter.sv
module flash_boot_arbiter #(
  parameter int ADDR_W     = 25,
  parameter int LEN_W      = 8,
  parameter int CLK_HALF   = 2,
  parameter int SETTLE_CYC = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic              ctl_wdata,
  output logic              ctl_owner,
  output logic              boot_busy,
  output logic              master_ready,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [LEN_W-1:0]  rd_len,
  output logic              rd_ready,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic              rd_done,
  output logic              rd_err,
  input  logic              m_sclk,
  input  logic              m_mosi,
  input  logic              m_cs_n,
  output logic              m_miso,
  output logic              spi_sclk,
  output logic              spi_mosi,
  output logic              spi_cs_n,
  output logic [ADDR_W-25:0] spi_bank,
  input  logic              spi_miso
);
  logic owner_master, switch_pend, eng_claim;
  logic b_sclk, b_mosi, b_cs_n, b_miso;

  flash_arb_owner_ctl #(.SETTLE_CYC(SETTLE_CYC)) u_owner (
    .clk          (clk),
    .rst_n        (rst_n),
    .ctl_wr       (ctl_wr),
    .ctl_wdata    (ctl_wdata),
    .eng_claim    (eng_claim),
    .owner_master (owner_master),
    .switch_pend  (switch_pend),
    .master_ready (master_ready)
  );

  flash_arb_read_seq #(
    .ADDR_W   (ADDR_W),
    .LEN_W    (LEN_W),
    .CLK_HALF (CLK_HALF)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (!owner_master && !switch_pend),
    .rd_req   (rd_req),
    .rd_addr  (rd_addr),
    .rd_len   (rd_len),
    .rd_ready (rd_ready),
    .rd_valid (rd_valid),
    .rd_data  (rd_data),
    .rd_done  (rd_done),
    .rd_err   (rd_err),
    .busy     (boot_busy),
    .claim    (eng_claim),
    .miso     (b_miso),
    .sclk     (b_sclk),
    .mosi     (b_mosi),
    .cs_n     (b_cs_n),
    .bank     (spi_bank)
  );

  flash_arb_pin_mux u_mux (
    .owner_master (owner_master),
    .b_sclk       (b_sclk),
    .b_mosi       (b_mosi),
    .b_cs_n       (b_cs_n),
    .b_miso       (b_miso),
    .m_sclk       (m_sclk),
    .m_mosi       (m_mosi),
    .m_cs_n       (m_cs_n),
    .m_miso       (m_miso),
    .spi_sclk     (spi_sclk),
    .spi_mosi     (spi_mosi),
    .spi_cs_n     (spi_cs_n),
    .spi_miso     (spi_miso)
  );

  assign ctl_owner = owner_master;
endmodule

// File: tb/flash_boot_arbiter_tb.sv
module flash_boot_arbiter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 20;

  logic        clk, rst_n;
  logic        ctl_wr, ctl_wdata, ctl_owner, boot_busy, master_ready;
  logic        rd_req, rd_ready, rd_valid, rd_done, rd_err;
  logic [24:0] rd_addr;
  logic [7:0]  rd_len, rd_data;
  logic        m_sclk, m_mosi, m_cs_n, m_miso;
  logic        spi_sclk, spi_mosi, spi_cs_n, spi_miso;
  logic [0:0]  spi_bank;
  logic        slv_miso, ovr_en, ovr_val;
  logic [31:0] slv_hdr;
  int          slv_cnt;
  int          n_chk, n_fail;

  // columns: offset, length, error expected
  localparam logic [33:0] VECS [0:5] = '{
    {25'h0000010, 8'd4,  1'b0},
    {25'h1ABCDEF, 8'd3,  1'b0},
    {25'h1FFFFFC, 8'd4,  1'b0},
    {25'h1FFFFFC, 8'd5,  1'b1},
    {25'h0000100, 8'd0,  1'b1},
    {25'h0123456, 8'd16, 1'b0}
  };

  assign spi_miso = ovr_en ? ovr_val : slv_miso;

  flash_boot_arbiter #(.ADDR_W(25), .LEN_W(8), .CLK_HALF(2), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_owner(ctl_owner), .boot_busy(boot_busy), .master_ready(master_ready),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_done(rd_done), .rd_err(rd_err),
    .m_sclk(m_sclk), .m_mosi(m_mosi), .m_cs_n(m_cs_n), .m_miso(m_miso),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n),
    .spi_bank(spi_bank), .spi_miso(spi_miso)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [7:0] pat(input logic [24:0] a);
    return a[7:0] ^ a[15:8] ^ {a[24], a[22:16]} ^ 8'hA5;
  endfunction

  // flash model: mode 0, header captured on rising clocks, data driven on falling clocks
  initial begin
    slv_cnt  = 0;
    slv_miso = 1'b0;
    slv_hdr  = '0;
  end
  always @(posedge spi_sclk or negedge spi_sclk or posedge spi_cs_n) begin
    if (spi_cs_n) begin
      slv_cnt  = 0;
      slv_miso = 1'b0;
    end else if (spi_sclk) begin
      if (slv_cnt < 32) slv_hdr = {slv_hdr[30:0], spi_mosi};
      slv_cnt = slv_cnt + 1;
    end else if (slv_cnt >= 32) begin
      logic [7:0] b;
      b = pat({spi_bank, slv_hdr[23:0]} + 25'((slv_cnt - 32) / 8));
      slv_miso = b[7 - ((slv_cnt - 32) % 8)];
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr_ctl(input logic v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic wait_ready();
    int g;
    g = 0;
    while (!rd_ready && g < 5000) begin @(negedge clk); g++; end
  endtask

  task automatic collect(input logic [24:0] a, input logic [7:0] n);
    int got, guard;
    got = 0; guard = 0;
    while (!rd_done && guard < 20000) begin
      if (rd_valid) begin
        chk(rd_data == pat(a + 25'(got)), "R2 data", int'(rd_data), int'(pat(a + 25'(got))));
        got++;
      end
      @(negedge clk); guard++;
    end
    chk(got == int'(n), "R2 byte count", got, int'(n));
    chk(boot_busy == 1'b0 && spi_cs_n == 1'b1, "R10 idle at done", int'({boot_busy, spi_cs_n}), 1);
  endtask

  task automatic do_read(input logic [24:0] a, input logic [7:0] n, input logic exp_err);
    wait_ready();
    rd_addr = a; rd_len = n; rd_req = 1'b1;
    @(negedge clk);
    rd_req = 1'b0;
    chk(rd_err == exp_err, "R6 error strobe", int'(rd_err), int'(exp_err));
    if (exp_err) begin
      @(negedge clk);
      chk(boot_busy == 1'b0 && spi_cs_n == 1'b1 && rd_err == 1'b0, "R6 no access",
          int'({boot_busy, spi_cs_n, rd_err}), 2);
    end else begin
      chk(boot_busy == 1'b1, "R10 busy after accept", int'(boot_busy), 1);
      collect(a, n);
      chk(slv_hdr == {8'h03, a[23:0]}, "R2 header", int'(slv_hdr), int'({8'h03, a[23:0]}));
      chk(spi_bank == a[24], "R2 bank", int'(spi_bank), int'(a[24]));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail = n_fail + 1;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    summary();
  end

  initial begin
    int k;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_wdata = 1'b0; rd_req = 1'b0;
    rd_addr = '0; rd_len = '0; m_sclk = 1'b0; m_mosi = 1'b0; m_cs_n = 1'b1;
    ovr_en = 1'b0; ovr_val = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(ctl_owner == 1'b0, "R1 owner", int'(ctl_owner), 0);
    chk(boot_busy == 1'b0 && master_ready == 1'b0, "R1 busy/ready", int'({boot_busy, master_ready}), 0);
    chk(spi_cs_n == 1'b1 && rd_ready == 1'b1, "R1 cs/ready", int'({spi_cs_n, rd_ready}), 3);

    // R9 boot owns: master miso isolated
    ovr_en = 1'b1; ovr_val = 1'b1; #1;
    chk(m_miso == 1'b0, "R9 miso isolated", int'(m_miso), 0);
    ovr_en = 1'b0;

    // vector table walk: R2 R6 R10
    for (int i = 0; i < 6; i++) begin
      do_read(VECS[i][33:9], VECS[i][8:1], VECS[i][0]);
    end

    // R3 switch when idle, R5 settle time
    wr_ctl(1'b1);
    chk(ctl_owner == 1'b1, "R3 switch idle", int'(ctl_owner), 1);
    chk(master_ready == 1'b0, "R5 not ready at switch", int'(master_ready), 0);
    k = 0;
    while (!master_ready && k < 100) begin @(negedge clk); k++; end
    chk(k == SETTLE, "R5 settle cycles", k, SETTLE);

    // R8 request ignored in master ownership
    chk(rd_ready == 1'b0, "R8 ready low", int'(rd_ready), 0);
    rd_addr = 25'h40; rd_len = 8'd2; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    chk(rd_err == 1'b0 && boot_busy == 1'b0, "R8 ignored", int'({rd_err, boot_busy}), 0);
    @(negedge clk);
    chk(boot_busy == 1'b0 && spi_cs_n == 1'b1, "R8 pins untouched", int'({boot_busy, spi_cs_n}), 1);

    // R9 master drives pins
    m_sclk = 1'b1; m_mosi = 1'b1; m_cs_n = 1'b0; ovr_en = 1'b1; ovr_val = 1'b1; #1;
    chk({spi_sclk, spi_mosi, spi_cs_n, m_miso} == 4'b1101, "R9 master pins",
        int'({spi_sclk, spi_mosi, spi_cs_n, m_miso}), 13);
    ovr_val = 1'b0; m_sclk = 1'b0; #1;
    chk(m_miso == 1'b0 && spi_sclk == 1'b0, "R9 master follow", int'({m_miso, spi_sclk}), 0);
    m_cs_n = 1'b1; m_mosi = 1'b0; ovr_en = 1'b0;
    @(negedge clk);

    // R7 return to boot, R5 ready drops
    wr_ctl(1'b0);
    chk(ctl_owner == 1'b0 && master_ready == 1'b0, "R7 back to boot", int'({ctl_owner, master_ready}), 0);

    // R4 switch request in the cycle a read is accepted
    wait_ready();
    rd_addr = 25'h0000321; rd_len = 8'd2; rd_req = 1'b1; ctl_wr = 1'b1; ctl_wdata = 1'b1;
    @(negedge clk);
    rd_req = 1'b0; ctl_wr = 1'b0;
    chk(boot_busy == 1'b1 && ctl_owner == 1'b0, "R4 held at accept", int'({boot_busy, ctl_owner}), 2);
    chk(rd_ready == 1'b0, "R4 ready low while pending", int'(rd_ready), 0);
    collect(25'h0000321, 8'd2);
    chk(ctl_owner == 1'b0, "R4 owner when busy falls", int'(ctl_owner), 0);
    @(negedge clk);
    chk(ctl_owner == 1'b1, "R4 owner after busy falls", int'(ctl_owner), 1);
    wr_ctl(1'b0);

    // R4 write during read, then R7 cancels the held switch
    wait_ready();
    rd_addr = 25'h0ABCDE0; rd_len = 8'd3; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    repeat (5) @(negedge clk);
    wr_ctl(1'b1);
    chk(ctl_owner == 1'b0 && boot_busy == 1'b1, "R4 pending while busy", int'({ctl_owner, boot_busy}), 1);
    repeat (5) @(negedge clk);
    wr_ctl(1'b0);
    collect(25'h0ABCDE0, 8'd3);
    repeat (2) @(negedge clk);
    chk(ctl_owner == 1'b0 && rd_ready == 1'b1, "R7 pending cancelled", int'({ctl_owner, rd_ready}), 1);

    summary();
  end
endmodule